// File: doc/BRIEF.md
# Ethernet Receive Frame Parser

This block sits behind a byte-wide receive interface in the style of MII or GMII. The interface carries a data byte, a data-valid strobe and an error strobe. While the line is idle the parser hunts for a preamble. It locks onto the start-of-frame delimiter and then walks through the frame. On the way it captures the two MAC addresses and the length/type word. It also counts bytes and runs a CRC-32 over everything up to and including the trailing check sequence.

When the frame closes, the parser raises a single-cycle summary pulse. The summary carries the captured fields, the frame length and a set of status flags. Alongside the flags for CRC, size and length/type, it reports spacing and preamble problems: a short inter-frame gap, a short preamble, and a malformed or cut-off preamble. The payload bytes leave on a separate stream with start and end markers. That stream runs four bytes behind the line, so that the check sequence is never forwarded.

Top module: `eth_rx_parser`

## Requirements
- R1: While hunting, a frame starts at the first 0xD5 byte, which may follow zero or more 0x55 bytes. `sum_pre_short` is set when fewer than MIN_PRE bytes of 0x55 came before that 0xD5.
- R2: The first six bytes after the delimiter form `sum_dst`, the next six form `sum_src`, and the two after those form `sum_lentype`. In each field the first byte on the line is the most significant.
- R3: `sum_len` counts bytes from the first destination byte to the last byte before the four check-sequence bytes. The count saturates at MAX_FRAME+1 total bytes, so it never exceeds MAX_FRAME-3.
- R4: The CRC-32 uses polynomial 0x04C11DB7, bit-reflected and starting from all ones, and covers every frame byte including the check sequence. `sum_crc_err` is set unless the reflected register ends at 0xDEBB20E3, which is 0xC704DD7B in normal bit order.
- R5: `sum_runt` is set when the total frame, check sequence included, is under MIN_FRAME bytes. `sum_oversize` is set when it is over MAX_FRAME bytes.
- R6: A length/type value of 1500 or less is a length. `sum_len_mismatch` is set when it differs from the payload count, which is `sum_len` minus 14. A value of 1536 or more sets `sum_is_type` and is never checked as a length. Values from 1501 to 1535 set neither flag.
- R7: `sum_ifg_short` is set when fewer than MIN_IFG cycles with rx_dv low passed between the end of the previous activity and the first byte of this one.
- R8: An rx_er byte with rx_dv high inside a frame aborts it at once. The summary then carries `sum_abort` with the CRC, size and length flags clear. The payload stream is closed with an end marker, and the remaining bytes are ignored until rx_dv falls.
- R9: An anomaly in the preamble produces a summary with `sum_abort` set. The anomaly is either a byte other than 0x55 or 0xD5 while hunting, or rx_dv falling after preamble bytes but before a delimiter. Bytes after a bad preamble byte are ignored until rx_dv falls, even when one of them is 0xD5.
- R10: Payload bytes are frame bytes 14 up to the last byte before the check sequence. Each leaves exactly once, in order, on `pl_data` with `pl_valid`. `pl_sop` marks the first byte and `pl_eop` marks the last. A frame of 18 bytes or fewer produces no payload.
- R11: rx_er while rx_dv is low has no effect and produces no summary.
- R12: After reset `sum_valid` and `pl_valid` are low. Each frame or abort yields exactly one `sum_valid` pulse, one cycle wide, one clock after rx_dv falls or after the aborting byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_dv | input | 1 | Byte valid / carrier |
| rx_er | input | 1 | Receive error strobe |
| sum_valid | output | 1 | One-cycle summary pulse |
| sum_dst | output | 48 | Destination MAC |
| sum_src | output | 48 | Source MAC |
| sum_lentype | output | 16 | Length/type word |
| sum_len | output | $clog2(MAX_FRAME+2) | Frame length without check sequence |
| sum_crc_err | output | 1 | CRC mismatch |
| sum_abort | output | 1 | Frame or preamble aborted |
| sum_runt | output | 1 | Frame under minimum size |
| sum_oversize | output | 1 | Frame over maximum size |
| sum_len_mismatch | output | 1 | Length field disagrees with payload |
| sum_is_type | output | 1 | Length/type word is an EtherType |
| sum_ifg_short | output | 1 | Preceding gap too short |
| sum_pre_short | output | 1 | Preamble shorter than MIN_PRE |
| pl_valid | output | 1 | Payload byte valid |
| pl_data | output | 8 | Payload byte |
| pl_sop | output | 1 | First payload byte |
| pl_eop | output | 1 | Last payload byte |

## Verification
The bench builds the parser with MIN_FRAME=20 and MAX_FRAME=40, keeping MIN_IFG=12 and MIN_PRE=7. With those sizes one sweep over every total length from 18 to 41 bytes, plus one at 45, covers every case below. It reaches the empty, one-byte and full payload, both sides of the runt and oversize limits, and the saturation of the length counter. The sweep also varies the preamble length and the gaps, including gaps of 11 and 12 idle cycles, and it corrupts some check sequences. Separate frames probe the length/type limits at 1500, 1501, 1535 and 1536, along with aborts at several byte positions and the malformed preamble cases.

// File: rtl/eth_rx_parser.sv
module eth_rx_parser #(
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int MIN_IFG   = 12,
  parameter int MIN_PRE   = 7,
  localparam int CW = $clog2(MAX_FRAME + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_data,
  input  logic          rx_dv,
  input  logic          rx_er,
  output logic          sum_valid,
  output logic [47:0]   sum_dst,
  output logic [47:0]   sum_src,
  output logic [15:0]   sum_lentype,
  output logic [CW-1:0] sum_len,
  output logic          sum_crc_err,
  output logic          sum_abort,
  output logic          sum_runt,
  output logic          sum_oversize,
  output logic          sum_len_mismatch,
  output logic          sum_is_type,
  output logic          sum_ifg_short,
  output logic          sum_pre_short,
  output logic          pl_valid,
  output logic [7:0]    pl_data,
  output logic          pl_sop,
  output logic          pl_eop
);
  localparam int GW = $clog2(MIN_IFG + 1);
  localparam int PW = $clog2(MIN_PRE + 1);
  localparam logic [31:0]   RESID   = 32'hDEBB20E3;
  localparam logic [CW-1:0] HDR_FCS = CW'(18);
  localparam logic [CW-1:0] CNT_SAT = CW'(MAX_FRAME + 1);

  typedef enum logic [1:0] {S_HUNT, S_DATA, S_DROP} state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  state_t        st;
  logic [PW-1:0] pre_n;
  logic [GW-1:0] gap;
  logic          ifg_bad, pre_bad;
  logic [CW-1:0] cnt;
  logic [31:0]   crc;
  logic [47:0]   da, sa;
  logic [15:0]   lt;
  logic [31:0]   win;
  logic [7:0]    pend_d;
  logic          pend_v, first;

  wire good_byte  = rx_dv && !rx_er;
  wire is_pre     = rx_data == 8'h55;
  wire is_sfd     = rx_data == 8'hD5;
  wire hunt_abort = (st == S_HUNT) && (rx_dv ? (rx_er || !(is_pre || is_sfd)) : (pre_n != '0));
  wire sfd_hit    = (st == S_HUNT) && good_byte && is_sfd;
  wire take       = (st == S_DATA) && good_byte;
  wire push       = take && (cnt >= HDR_FCS);
  wire data_end   = (st == S_DATA) && !rx_dv;
  wire data_abort = (st == S_DATA) && rx_dv && rx_er;
  wire close      = data_end || data_abort;
  wire gap_short  = gap < GW'(MIN_IFG);
  wire ifg_now    = (pre_n == '0) ? gap_short : ifg_bad;
  wire [CW-1:0] len_now = (cnt < CW'(4)) ? '0 : cnt - CW'(4);
  wire len_mm = (lt <= 16'd1500) && ((cnt < HDR_FCS) || (32'(lt) != 32'(cnt - HDR_FCS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HUNT;
      pre_n <= '0;
      gap <= GW'(MIN_IFG);
      ifg_bad <= 1'b0;
      pre_bad <= 1'b0;
      cnt <= '0;
      crc <= '1;
      da <= '0;
      sa <= '0;
      lt <= '0;
      win <= '0;
      pend_d <= '0;
      pend_v <= 1'b0;
      first <= 1'b0;
    end else begin
      if (rx_dv) gap <= '0;
      else if (gap_short) gap <= gap + GW'(1);

      case (st)
        S_HUNT: begin
          if (rx_dv && pre_n == '0) ifg_bad <= gap_short;
          if (!rx_dv) pre_n <= '0;
          else if (hunt_abort) begin
            pre_n <= '0;
            st <= S_DROP;
          end else if (sfd_hit) begin
            pre_bad <= pre_n < PW'(MIN_PRE);
            pre_n <= '0;
            cnt <= '0;
            crc <= '1;
            first <= 1'b1;
            pend_v <= 1'b0;
            st <= S_DATA;
          end else if (pre_n != PW'(MIN_PRE)) pre_n <= pre_n + PW'(1);
        end
        S_DATA: begin
          if (data_end) st <= S_HUNT;
          else if (data_abort) st <= S_DROP;
          if (close) pend_v <= 1'b0;
          if (take) begin
            crc <= crc_step(crc, rx_data);
            win <= {win[23:0], rx_data};
            if (cnt != CNT_SAT) cnt <= cnt + CW'(1);
            if (cnt < CW'(6)) da <= {da[39:0], rx_data};
            else if (cnt < CW'(12)) sa <= {sa[39:0], rx_data};
            else if (cnt < CW'(14)) lt <= {lt[7:0], rx_data};
          end
          if (push) begin
            pend_d <= win[31:24];
            pend_v <= 1'b1;
            if (pend_v) first <= 1'b0;
          end
        end
        default: if (!rx_dv) st <= S_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_valid <= 1'b0;
      sum_dst <= '0;
      sum_src <= '0;
      sum_lentype <= '0;
      sum_len <= '0;
      sum_crc_err <= 1'b0;
      sum_abort <= 1'b0;
      sum_runt <= 1'b0;
      sum_oversize <= 1'b0;
      sum_len_mismatch <= 1'b0;
      sum_is_type <= 1'b0;
      sum_ifg_short <= 1'b0;
      sum_pre_short <= 1'b0;
    end else begin
      sum_valid <= close || hunt_abort;
      if (hunt_abort) begin
        sum_len <= '0;
        sum_abort <= 1'b1;
        sum_crc_err <= 1'b0;
        sum_runt <= 1'b0;
        sum_oversize <= 1'b0;
        sum_len_mismatch <= 1'b0;
        sum_is_type <= 1'b0;
        sum_ifg_short <= ifg_now;
        sum_pre_short <= 1'b0;
      end else if (close) begin
        sum_dst <= da;
        sum_src <= sa;
        sum_lentype <= lt;
        sum_len <= len_now;
        sum_abort <= data_abort;
        sum_crc_err <= data_end && (crc != RESID);
        sum_runt <= data_end && (cnt < CW'(MIN_FRAME));
        sum_oversize <= data_end && (cnt > CW'(MAX_FRAME));
        sum_len_mismatch <= data_end && len_mm;
        sum_is_type <= lt >= 16'd1536;
        sum_ifg_short <= ifg_bad;
        sum_pre_short <= pre_bad;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_valid <= 1'b0;
      pl_data <= '0;
      pl_sop <= 1'b0;
      pl_eop <= 1'b0;
    end else begin
      pl_valid <= pend_v && (push || close);
      if (pend_v && (push || close)) begin
        pl_data <= pend_d;
        pl_sop <= first;
        pl_eop <= close;
      end
    end
  end
endmodule

// File: rtl/eth_rx_parser_chk.sv
module eth_rx_parser_chk #(
  parameter int MAX_FRAME = 1518,
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sum_valid,
  input logic [CW-1:0] sum_len,
  input logic          sum_crc_err,
  input logic          sum_abort,
  input logic          sum_runt,
  input logic          sum_oversize,
  input logic          sum_len_mismatch,
  input logic          sum_is_type,
  input logic          pl_valid,
  input logic          pl_sop,
  input logic          pl_eop
);
  logic in_pkt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_pkt <= 1'b0;
    else if (pl_valid) in_pkt <= !pl_eop;
  end

  p_sum_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |=> !sum_valid);
  p_abort_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_valid && sum_abort) |-> !(sum_crc_err || sum_runt || sum_oversize || sum_len_mismatch));
  p_size_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> !(sum_runt && sum_oversize));
  p_type_nolen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> !(sum_is_type && sum_len_mismatch));
  p_len_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> (32'(sum_len) <= 32'(MAX_FRAME - 3)));
  p_sop_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && !in_pkt) |-> pl_sop);
  p_sop_inside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && in_pkt) |-> !pl_sop);
endmodule

bind eth_rx_parser eth_rx_parser_chk #(.MAX_FRAME(MAX_FRAME), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sum_valid(sum_valid), .sum_len(sum_len),
  .sum_crc_err(sum_crc_err), .sum_abort(sum_abort), .sum_runt(sum_runt),
  .sum_oversize(sum_oversize), .sum_len_mismatch(sum_len_mismatch),
  .sum_is_type(sum_is_type), .pl_valid(pl_valid), .pl_sop(pl_sop), .pl_eop(pl_eop)
);

// File: tb/eth_rx_parser_tb.sv
module eth_rx_parser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MINF = 20;
  localparam int MAXF = 40;
  localparam int CWB  = $clog2(MAXF + 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_dv = 1'b0, rx_er = 1'b0;
  logic sum_valid, sum_crc_err, sum_abort, sum_runt, sum_oversize;
  logic sum_len_mismatch, sum_is_type, sum_ifg_short, sum_pre_short;
  logic [47:0] sum_dst, sum_src;
  logic [15:0] sum_lentype;
  logic [CWB-1:0] sum_len;
  logic pl_valid, pl_sop, pl_eop;
  logic [7:0] pl_data;

  eth_rx_parser #(.MIN_FRAME(MINF), .MAX_FRAME(MAXF), .MIN_IFG(12), .MIN_PRE(7)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_dv(rx_dv), .rx_er(rx_er),
    .sum_valid(sum_valid), .sum_dst(sum_dst), .sum_src(sum_src), .sum_lentype(sum_lentype),
    .sum_len(sum_len), .sum_crc_err(sum_crc_err), .sum_abort(sum_abort), .sum_runt(sum_runt),
    .sum_oversize(sum_oversize), .sum_len_mismatch(sum_len_mismatch), .sum_is_type(sum_is_type),
    .sum_ifg_short(sum_ifg_short), .sum_pre_short(sum_pre_short),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_sop(pl_sop), .pl_eop(pl_eop)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nchk = 0, nerr = 0, nsum = 0, pl_n = 0, nsop = 0, neop = 0, last_gap = 100;
  logic [7:0] fb [0:63];
  logic [7:0] pl_buf [0:63];
  logic [47:0] c_dst, c_src;
  logic [15:0] c_lt;
  int c_len;
  logic c_crc, c_abort, c_runt, c_ovs, c_mm, c_type, c_ifg, c_pre;

  always @(negedge clk) if (rst_n) begin
    if (sum_valid) begin
      nsum++;
      c_dst = sum_dst; c_src = sum_src; c_lt = sum_lentype; c_len = int'(sum_len);
      c_crc = sum_crc_err; c_abort = sum_abort; c_runt = sum_runt; c_ovs = sum_oversize;
      c_mm = sum_len_mismatch; c_type = sum_is_type; c_ifg = sum_ifg_short; c_pre = sum_pre_short;
    end
    if (pl_valid) begin
      if (pl_sop) nsop++;
      if (pl_eop) neop++;
      if (pl_n < 64) pl_buf[pl_n] = pl_data;
      pl_n++;
    end
  end

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(int n);
    logic [31:0] c = '1;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ fb[i][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  task automatic build(int t, logic [15:0] ltv, bit bad);
    logic [31:0] f;
    for (int i = 0; i < 6; i++) begin
      fb[i] = 8'h10 + 8'(i);
      fb[6 + i] = 8'hA0 + 8'(i);
    end
    fb[12] = ltv[15:8];
    fb[13] = ltv[7:0];
    for (int i = 14; i < t - 4; i++) fb[i] = 8'(i * 7 + t);
    f = fcs_of(t - 4);
    fb[t-4] = f[7:0]; fb[t-3] = f[15:8]; fb[t-2] = f[23:16]; fb[t-1] = f[31:24];
    if (bad) fb[t-1] = fb[t-1] ^ 8'h01;
  endtask

  task automatic put(bit dv, bit er, logic [7:0] d);
    @(negedge clk);
    rx_dv = dv; rx_er = er; rx_data = d;
  endtask

  task automatic send(int pre, int t, int er_at);
    for (int i = 0; i < pre; i++) put(1, 0, 8'h55);
    put(1, 0, 8'hD5);
    for (int i = 0; i < t; i++) put(1, i == er_at, fb[i]);
    last_gap = 0;
  endtask

  task automatic idle(int n, bit erp);
    for (int i = 0; i < n; i++) put(0, erp && (i == n / 2), 8'h00);
    last_gap += n;
  endtask

  task automatic clear_mon(output int s0);
    s0 = nsum; pl_n = 0; nsop = 0; neop = 0;
  endtask

  task automatic pl_bytes(string tag, int n);
    int bad = 0;
    for (int i = 0; i < n && i < 64; i++) if (pl_buf[i] != fb[14 + i]) bad++;
    check(tag, bad, 0);
  endtask

  task automatic frame(int pre, int t, logic [15:0] ltv, bit bad, int gap);
    int s0, lexp, pn;
    bit ifg_exp;
    ifg_exp = last_gap < 12;
    clear_mon(s0);
    build(t, ltv, bad);
    send(pre, t, -1);
    idle(gap, 0);
    #2;
    lexp = ((t < MAXF + 1) ? t : MAXF + 1) - 4;
    pn = t - 18;
    check("R12 one summary", nsum - s0, 1);
    check("R8 no abort", int'(c_abort), 0);
    check("R4 crc flag", int'(c_crc), int'(bad));
    check("R3 length", c_len, lexp);
    check("R5 runt", int'(c_runt), int'(t < MINF));
    check("R5 oversize", int'(c_ovs), int'(t > MAXF));
    check("R2 dst", int'(c_dst == 48'h101112131415), 1);
    check("R2 src", int'(c_src == 48'hA0A1A2A3A4A5), 1);
    check("R2 lentype", int'(c_lt), int'(ltv));
    check("R6 is_type", int'(c_type), int'(ltv >= 16'd1536));
    check("R6 mismatch", int'(c_mm), int'(ltv <= 16'd1500 && int'(ltv) != pn));
    check("R7 ifg", int'(c_ifg), int'(ifg_exp));
    check("R1 pre_short", int'(c_pre), int'(pre < 7));
    check("R10 count", pl_n, pn);
    check("R10 sop", nsop, int'(pn > 0));
    check("R10 eop", neop, int'(pn > 0));
    pl_bytes("R10 bytes", pn);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nerr++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int s0;
    int lts [4] = '{1500, 1501, 1535, 1536};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R12 reset sum_valid", int'(sum_valid), 0);
    check("R12 reset pl_valid", int'(pl_valid), 0);

    for (int t = 18; t <= 41; t++) begin
      logic [15:0] ltv;
      int pre;
      ltv = (t % 3 == 0) ? 16'h0800 : ((t % 2 == 0) ? 16'(t - 18) : 16'(t - 17));
      pre = (t == 22) ? 0 : (t % 5 == 0) ? 3 : (t % 5 == 1) ? 10 : 7;
      frame(pre, t, ltv, t % 4 == 1, (t % 6 == 2) ? 11 : 12);
    end
    frame(7, 45, 16'h0800, 0, 12);
    foreach (lts[i]) frame(7, 30, 16'(lts[i]), 0, 12);

    // R8: error strobe late in a frame, payload closed early
    clear_mon(s0);
    build(30, 16'h000C, 0);
    send(7, 30, 25);
    idle(12, 0); #2;
    check("R8 one summary", nsum - s0, 1);
    check("R8 abort", int'(c_abort), 1);
    check("R8 crc clear", int'(c_crc), 0);
    check("R8 payload count", pl_n, 7);
    check("R8 payload eop", neop, 1);
    pl_bytes("R8 payload bytes", 7);

    // R8: error strobe inside the header
    clear_mon(s0);
    send(7, 30, 10);
    idle(12, 0); #2;
    check("R8 early one summary", nsum - s0, 1);
    check("R8 early abort", int'(c_abort), 1);
    check("R8 early payload", pl_n, 0);

    // R9: carrier drops inside the preamble
    clear_mon(s0);
    for (int i = 0; i < 4; i++) put(1, 0, 8'h55);
    last_gap = 0;
    idle(12, 0); #2;
    check("R9 cut preamble summary", nsum - s0, 1);
    check("R9 cut preamble abort", int'(c_abort), 1);

    // R9: bad preamble byte, later delimiter bytes ignored
    clear_mon(s0);
    put(1, 0, 8'h55); put(1, 0, 8'h55); put(1, 0, 8'h5A);
    for (int i = 0; i < 20; i++) put(1, 0, 8'hD5);
    last_gap = 0;
    idle(12, 0); #2;
    check("R9 bad byte summary", nsum - s0, 1);
    check("R9 bad byte abort", int'(c_abort), 1);
    check("R9 bad byte payload", pl_n, 0);
    frame(7, 24, 16'h0006, 0, 12);

    // R11: error strobe while idle
    clear_mon(s0);
    idle(12, 1); #2;
    check("R11 idle error no summary", nsum - s0, 0);
    frame(7, 26, 16'h0008, 0, 12);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule